// File: doc/BRIEF.md
# Exception Entry Controller

This block turns one exception request into the full set of register updates a processor core needs when it takes an exception. The pipeline presents a request code, the program counter of the faulting instruction, a flag saying whether that instruction sits in a branch delay slot, and the current status, cause, debug-control and exception-base values. On the next clock edge the block presents the new program counter, one saved return address with its write enable, and updated status, cause and debug-control words.

There are three entry schemes. General exceptions save to the exception return register and vector off a selectable base. Error-level entries (soft reset and non-maskable interrupt) save to the error return register and jump to a fixed boot address. Debug entries save to the debug return register, set a debug-mode flag and jump to a fixed debug address. Each scheme has its own delay-slot adjustment and its own rule for when the status exception-level bit gates the update.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted every output is zero.
- R2: A general exception jumps to base plus offset, where base is 0xBFC00200 when status bit 22 (boot vectors) is set and otherwise the exception-base input with its low 10 bits forced to zero; the default offset is 0x180.
- R3: An interrupt (request code 0) uses offset 0x200 when cause bit 23 (separate interrupt vector) is set.
- R4: A TLB load or store miss (codes 2, 3) flagged as a refill while status bit 1 (exception level) is clear uses offset 0x000, or 0x080 when the wide-mode input is set and the bad-address region (0, 1, 3) has its extended-addressing enable set (status bits 5, 6, 7 respectively).
- R5: A cache error (code 30) uses offset 0x100 when status bit 22 is set and 0x20000100 otherwise.
- R6: For a general exception with status bit 1 clear, the exception return register is written with PC-4 from a delay slot (cause bit 31 set) or PC otherwise (cause bit 31 cleared), status bit 1 is set and status bits 4:3 (privilege) are cleared; with status bit 1 set, no return register is written and bit 31 and status are unchanged.
- R7: Request codes 0 to 31 are general exceptions whose code is copied into cause bits 6:2; legal values are 0-13, 15, 18, 22-25 and 30. Code 11 also writes the coprocessor number input into cause bits 29:28.
- R8: Code 38 (soft reset) sets status bit 20 and code 39 (NMI) sets status bit 19; both write the error return register with the delay-slot adjustment, set status bits 2 and 22, clear bits 4:3, and jump to 0xBFC00000.
- R9: Codes 32 to 37 are debug entries (single step, interrupt, instruction break, breakpoint, data store break, data load break) that set debug-control bit 0, 5, 4, 1, 3, 2 respectively, write the debug return register (single step never adjusts for a delay slot), raise debug mode, clear status bits 4:3 and jump to 0xBFC00480.
- R10: An interrupt request while debug mode is active is taken as a debug interrupt (code 33).
- R11: Error and debug entries clear cause bit 31 only when status bit 1 is clear; every accepted entry pulses the delay-slot clear output.
- R12: Any other code raises the error output for one cycle, writes no return register, and passes status, cause, debug-control and debug mode through unchanged.
- R13: Results appear on the clock edge after the request, for one cycle, with at most one return-register write enable active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request present |
| req_code | input | 6 | Request code (see R7-R9) |
| req_pc | input | AW | PC of the faulting instruction |
| in_slot | input | 1 | Instruction is in a branch delay slot |
| tlb_refill | input | 1 | TLB miss is a refill |
| cu_num | input | 2 | Unusable coprocessor number |
| bad_region | input | 2 | Top two bits of the bad virtual address |
| wide_mode | input | 1 | 64-bit addressing mode |
| dbg_mode_i | input | 1 | Debug mode currently active |
| status_i | input | 32 | Current status register |
| cause_i | input | 32 | Current cause register |
| debug_i | input | 32 | Current debug-control register |
| ebase_i | input | AW | Exception-base register |
| wb_valid | output | 1 | Entry accepted, updates valid |
| wb_err | output | 1 | Illegal request code |
| pc_o | output | AW | New program counter |
| epc_we | output | 1 | Write exception return register |
| epc_o | output | AW | Return address |
| errepc_we | output | 1 | Write error return register |
| errepc_o | output | AW | Return address |
| depc_we | output | 1 | Write debug return register |
| depc_o | output | AW | Return address |
| status_o | output | 32 | Updated status |
| cause_o | output | 32 | Updated cause |
| debug_o | output | 32 | Updated debug-control |
| dbg_mode_o | output | 1 | Debug mode after entry |
| slot_clr | output | 1 | Clear the delay-slot flag |

## Verification
Every one of the 64 request codes is applied with and without a delay slot under all four combinations of exception level and boot-vector select, which separates the three save schemes, the EXL gating of the return address and branch-delay bit, and the two base choices. A table of hand-worked vectors pins the absolute vector addresses for interrupts with and without the separate vector, refill and non-refill TLB misses, cache errors under both bases, and the error and debug entries. Directed cases walk the wide refill through each address region and enable, the coprocessor number, an interrupt arriving in debug mode, and an illegal code that must leave every register untouched.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W = 6;

  // status bit positions
  localparam int ST_EXL    = 1;
  localparam int ST_ERL    = 2;
  localparam int ST_KSU_LO = 3;
  localparam int ST_UX     = 5;
  localparam int ST_SX     = 6;
  localparam int ST_KX     = 7;
  localparam int ST_NMI    = 19;
  localparam int ST_SR     = 20;
  localparam int ST_BEV    = 22;

  // cause bit positions
  localparam int CA_EXC_LO = 2;
  localparam int CA_IV     = 23;
  localparam int CA_CE_LO  = 28;
  localparam int CA_BD     = 31;

  // debug-control bit positions
  localparam int DB_DSS  = 0;
  localparam int DB_DBP  = 1;
  localparam int DB_DDBL = 2;
  localparam int DB_DDBS = 3;
  localparam int DB_DIB  = 4;
  localparam int DB_DINT = 5;

  // request codes
  localparam logic [CODE_W-1:0] RQ_IRQ   = 6'd0;
  localparam logic [CODE_W-1:0] RQ_TLBL  = 6'd2;
  localparam logic [CODE_W-1:0] RQ_TLBS  = 6'd3;
  localparam logic [CODE_W-1:0] RQ_CPU   = 6'd11;
  localparam logic [CODE_W-1:0] RQ_CACHE = 6'd30;
  localparam logic [CODE_W-1:0] RQ_DSS   = 6'd32;
  localparam logic [CODE_W-1:0] RQ_DINT  = 6'd33;
  localparam logic [CODE_W-1:0] RQ_DIB   = 6'd34;
  localparam logic [CODE_W-1:0] RQ_DBP   = 6'd35;
  localparam logic [CODE_W-1:0] RQ_DDBS  = 6'd36;
  localparam logic [CODE_W-1:0] RQ_DDBL  = 6'd37;
  localparam logic [CODE_W-1:0] RQ_SRST  = 6'd38;
  localparam logic [CODE_W-1:0] RQ_NMI   = 6'd39;

  // fixed vectors
  localparam logic [31:0] VEC_GEN_BOOT = 32'hBFC0_0200;
  localparam logic [31:0] VEC_ERR      = 32'hBFC0_0000;
  localparam logic [31:0] VEC_DBG      = 32'hBFC0_0480;

  typedef enum logic [1:0] {EK_GEN, EK_ERR, EK_DBG, EK_BAD} entry_kind_e;

  // legal general exception codes
  function automatic logic gen_code_ok(input logic [4:0] c);
    case (c)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9,
      5'd10, 5'd11, 5'd12, 5'd13, 5'd15, 5'd18,
      5'd22, 5'd23, 5'd24, 5'd25, 5'd30: gen_code_ok = 1'b1;
      default:                          gen_code_ok = 1'b0;
    endcase
  endfunction

  // vector offset for a general exception
  function automatic logic [31:0] gen_offset(
    input logic [4:0] c, input logic refill, input logic exl,
    input logic bev, input logic iv, input logic ext_refill);
    gen_offset = 32'h0000_0180;
    if (c == RQ_IRQ[4:0] && iv)
      gen_offset = 32'h0000_0200;
    else if ((c == RQ_TLBL[4:0] || c == RQ_TLBS[4:0]) && refill && !exl)
      gen_offset = ext_refill ? 32'h0000_0080 : 32'h0000_0000;
    else if (c == RQ_CACHE[4:0])
      gen_offset = bev ? 32'h0000_0100 : 32'h2000_0100;
  endfunction

  // extended refill selection by address region
  function automatic logic ext_refill_sel(
    input logic wide, input logic [1:0] region,
    input logic ux, input logic sx, input logic kx);
    case (region)
      2'd0:    ext_refill_sel = wide & ux;
      2'd1:    ext_refill_sel = wide & sx;
      2'd3:    ext_refill_sel = wide & kx;
      default: ext_refill_sel = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [CODE_W-1:0] req_code,
  input  logic              in_debug,
  output entry_kind_e       kind,
  output logic [4:0]        exc_code,
  output logic [31:0]       dbg_mask,
  output logic              sstep,
  output logic              is_sreset
);
  logic [CODE_W-1:0] eff_code;

  always_comb begin
    eff_code = (req_code == RQ_IRQ && in_debug) ? RQ_DINT : req_code;
    exc_code = eff_code[4:0];
    dbg_mask = '0;
    kind     = EK_BAD;
    if (!eff_code[5]) begin
      kind = gen_code_ok(eff_code[4:0]) ? EK_GEN : EK_BAD;
    end else begin
      case (eff_code)
        RQ_DSS:  begin kind = EK_DBG; dbg_mask[DB_DSS]  = 1'b1; end
        RQ_DINT: begin kind = EK_DBG; dbg_mask[DB_DINT] = 1'b1; end
        RQ_DIB:  begin kind = EK_DBG; dbg_mask[DB_DIB]  = 1'b1; end
        RQ_DBP:  begin kind = EK_DBG; dbg_mask[DB_DBP]  = 1'b1; end
        RQ_DDBS: begin kind = EK_DBG; dbg_mask[DB_DDBS] = 1'b1; end
        RQ_DDBL: begin kind = EK_DBG; dbg_mask[DB_DDBL] = 1'b1; end
        RQ_SRST, RQ_NMI: kind = EK_ERR;
        default: kind = EK_BAD;
      endcase
    end
    sstep     = (eff_code == RQ_DSS);
    is_sreset = (eff_code == RQ_SRST);
  end

  // R10: an interrupt in debug mode must come out as a debug interrupt
  always_comb begin
    if (in_debug && req_code == RQ_IRQ)
      assert_irq_redirect_R10: assert (kind == EK_DBG && dbg_mask[DB_DINT])
        else $error("interrupt in debug mode not redirected");
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int AW = 32
) (
  input  entry_kind_e   kind,
  input  logic [4:0]    exc_code,
  input  logic          refill,
  input  logic [31:0]   status,
  input  logic          iv,
  input  logic          wide_mode,
  input  logic [1:0]    region,
  input  logic [AW-1:0] ebase,
  output logic [AW-1:0] target,
  output logic [31:0]   vec_off
);
  localparam int LOW_BITS = 10;

  logic          bev;
  logic          ext_refill;
  logic [AW-1:0] gen_base;

  assign bev        = status[ST_BEV];
  assign ext_refill = ext_refill_sel(wide_mode, region, status[ST_UX],
                                     status[ST_SX], status[ST_KX]);
  assign vec_off    = gen_offset(exc_code, refill, status[ST_EXL], bev, iv, ext_refill);
  assign gen_base   = bev ? AW'(VEC_GEN_BOOT) : {ebase[AW-1:LOW_BITS], {LOW_BITS{1'b0}}};

  always_comb begin
    case (kind)
      EK_GEN:  target = gen_base + AW'(vec_off);
      EK_ERR:  target = AW'(VEC_ERR);
      EK_DBG:  target = AW'(VEC_DBG);
      default: target = '0;
    endcase
  end

  // R2: with a software base the low bits of the target are the offset's
  always_comb begin
    if (kind == EK_GEN && !bev)
      assert_vec_align_R2: assert (target[LOW_BITS-1:0] == vec_off[LOW_BITS-1:0])
        else $error("general vector not aligned to base");
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic [AW-1:0]     req_pc,
  input  logic              in_slot,
  input  logic              tlb_refill,
  input  logic [1:0]        cu_num,
  input  logic [1:0]        bad_region,
  input  logic              wide_mode,
  input  logic              dbg_mode_i,
  input  logic [31:0]       status_i,
  input  logic [31:0]       cause_i,
  input  logic [31:0]       debug_i,
  input  logic [AW-1:0]     ebase_i,
  output logic              wb_valid,
  output logic              wb_err,
  output logic [AW-1:0]     pc_o,
  output logic              epc_we,
  output logic [AW-1:0]     epc_o,
  output logic              errepc_we,
  output logic [AW-1:0]     errepc_o,
  output logic              depc_we,
  output logic [AW-1:0]     depc_o,
  output logic [31:0]       status_o,
  output logic [31:0]       cause_o,
  output logic [31:0]       debug_o,
  output logic              dbg_mode_o,
  output logic              slot_clr
);
  localparam logic [AW-1:0] INSN_BYTES = AW'(4);

  entry_kind_e   kind;
  logic [4:0]    exc_code;
  logic [31:0]   dbg_mask;
  logic          sstep;
  logic          is_sreset;
  logic [AW-1:0] target;
  logic [31:0]   vec_off;
  logic          exl;
  logic [AW-1:0] ret_addr;

  exc_classify u_classify (
    .req_code  (req_code),
    .in_debug  (dbg_mode_i),
    .kind      (kind),
    .exc_code  (exc_code),
    .dbg_mask  (dbg_mask),
    .sstep     (sstep),
    .is_sreset (is_sreset)
  );

  exc_vector #(.AW(AW)) u_vector (
    .kind      (kind),
    .exc_code  (exc_code),
    .refill    (tlb_refill),
    .status    (status_i),
    .iv        (cause_i[CA_IV]),
    .wide_mode (wide_mode),
    .region    (bad_region),
    .ebase     (ebase_i),
    .target    (target),
    .vec_off   (vec_off)
  );

  assign exl      = status_i[ST_EXL];
  assign ret_addr = (in_slot && !sstep) ? req_pc - INSN_BYTES : req_pc;

  // next-state of the write-back word
  logic        n_valid, n_err, n_epc_we, n_errepc_we, n_depc_we, n_dm;
  logic [31:0] n_status, n_cause, n_debug;

  always_comb begin
    n_valid     = 1'b0;
    n_err       = 1'b0;
    n_epc_we    = 1'b0;
    n_errepc_we = 1'b0;
    n_depc_we   = 1'b0;
    n_dm        = dbg_mode_i;
    n_status    = status_i;
    n_cause     = cause_i;
    n_debug     = debug_i;
    if (req_valid) begin
      case (kind)
        EK_GEN: begin
          n_valid = 1'b1;
          if (!exl) begin
            n_epc_we                     = 1'b1;
            n_cause[CA_BD]               = in_slot;
            n_status[ST_EXL]             = 1'b1;
            n_status[ST_KSU_LO+1:ST_KSU_LO] = 2'b00;
          end
          n_cause[CA_EXC_LO+4:CA_EXC_LO] = exc_code;
          if (exc_code == RQ_CPU[4:0])
            n_cause[CA_CE_LO+1:CA_CE_LO] = cu_num;
        end
        EK_ERR: begin
          n_valid     = 1'b1;
          n_errepc_we = 1'b1;
          if (is_sreset) n_status[ST_SR]  = 1'b1;
          else           n_status[ST_NMI] = 1'b1;
          n_status[ST_ERL] = 1'b1;
          n_status[ST_BEV] = 1'b1;
          n_status[ST_KSU_LO+1:ST_KSU_LO] = 2'b00;
          if (!exl) n_cause[CA_BD] = 1'b0;
        end
        EK_DBG: begin
          n_valid   = 1'b1;
          n_depc_we = 1'b1;
          n_dm      = 1'b1;
          n_debug   = debug_i | dbg_mask;
          n_status[ST_KSU_LO+1:ST_KSU_LO] = 2'b00;
          if (!exl) n_cause[CA_BD] = 1'b0;
        end
        default: n_err = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid   <= 1'b0;
      wb_err     <= 1'b0;
      pc_o       <= '0;
      epc_we     <= 1'b0;
      epc_o      <= '0;
      errepc_we  <= 1'b0;
      errepc_o   <= '0;
      depc_we    <= 1'b0;
      depc_o     <= '0;
      status_o   <= '0;
      cause_o    <= '0;
      debug_o    <= '0;
      dbg_mode_o <= 1'b0;
      slot_clr   <= 1'b0;
    end else begin
      wb_valid  <= n_valid;
      wb_err    <= n_err;
      epc_we    <= n_epc_we;
      errepc_we <= n_errepc_we;
      depc_we   <= n_depc_we;
      slot_clr  <= n_valid;
      if (req_valid) begin
        pc_o       <= target;
        epc_o      <= ret_addr;
        errepc_o   <= ret_addr;
        depc_o     <= ret_addr;
        status_o   <= n_status;
        cause_o    <= n_cause;
        debug_o    <= n_debug;
        dbg_mode_o <= n_dm;
      end
    end
  end

  // R13: never more than one return register written
  assert_single_save_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({epc_we, errepc_we, depc_we}));

  // R13: a request yields exactly one result cycle, nothing without one
  assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(req_valid) |-> (wb_valid ^ wb_err));
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !wb_valid && !wb_err);

  // R12: an illegal code writes nothing and passes registers through
  assert_err_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && wb_err |-> !epc_we && !errepc_we && !depc_we &&
      status_o == $past(status_i) && cause_o == $past(cause_i));

  // R6: exception level set blocks the general return register
  assert_exl_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(req_valid && kind == EK_GEN && exl) |-> wb_valid && !epc_we);

  // R8: error entries land on the boot vector with ERL and BEV set
  assert_err_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    errepc_we |-> pc_o == AW'(VEC_ERR) && status_o[ST_ERL] && status_o[ST_BEV]);

  // R9: debug entries land on the debug vector in debug mode
  assert_dbg_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    depc_we |-> pc_o == AW'(VEC_DBG) && dbg_mode_o);
endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EBASE = 32'h8000_05A4;
  localparam logic [31:0] DBGV  = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_code = '0;
  logic [31:0] req_pc = '0;
  logic        in_slot = 1'b0;
  logic        tlb_refill = 1'b0;
  logic [1:0]  cu_num = '0;
  logic [1:0]  bad_region = '0;
  logic        wide_mode = 1'b0;
  logic        dbg_mode_i = 1'b0;
  logic [31:0] status_i = '0;
  logic [31:0] cause_i = '0;
  logic [31:0] debug_i = DBGV;
  logic [31:0] ebase_i = EBASE;
  logic        wb_valid, wb_err, epc_we, errepc_we, depc_we, dbg_mode_o, slot_clr;
  logic [31:0] pc_o, epc_o, errepc_o, depc_o, status_o, cause_o, debug_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_pc(req_pc), .in_slot(in_slot), .tlb_refill(tlb_refill), .cu_num(cu_num),
    .bad_region(bad_region), .wide_mode(wide_mode), .dbg_mode_i(dbg_mode_i),
    .status_i(status_i), .cause_i(cause_i), .debug_i(debug_i), .ebase_i(ebase_i),
    .wb_valid(wb_valid), .wb_err(wb_err), .pc_o(pc_o), .epc_we(epc_we), .epc_o(epc_o),
    .errepc_we(errepc_we), .errepc_o(errepc_o), .depc_we(depc_we), .depc_o(depc_o),
    .status_o(status_o), .cause_o(cause_o), .debug_o(debug_o),
    .dbg_mode_o(dbg_mode_o), .slot_clr(slot_clr));

  typedef struct packed {
    logic v, e, ew, rw, dw, dm;
    logic [31:0] pc, sav, st, ca, db;
  } exp_t;

  typedef struct packed {
    logic [5:0]  code;
    logic        slot;
    logic        refill;
    logic [31:0] st;
    logic [31:0] ca;
    logic [31:0] exp_pc;
  } tv_t;

  // hand-worked vectors; software base resolves to 0x80000400
  localparam int NTV = 11;
  localparam tv_t TV [NTV] = '{
    '{6'd8,  1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h8000_0580},
    '{6'd8,  1'b0, 1'b0, 32'h0040_0000, 32'h0000_0000, 32'hBFC0_0380},
    '{6'd0,  1'b0, 1'b0, 32'h0000_0000, 32'h0080_0000, 32'h8000_0600},
    '{6'd2,  1'b0, 1'b1, 32'h0040_0000, 32'h0000_0000, 32'hBFC0_0200},
    '{6'd2,  1'b1, 1'b1, 32'h0000_0002, 32'h0000_0000, 32'h8000_0580},
    '{6'd30, 1'b0, 1'b0, 32'h0040_0000, 32'h0000_0000, 32'hBFC0_0300},
    '{6'd30, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'hA000_0500},
    '{6'd38, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'hBFC0_0000},
    '{6'd39, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0000, 32'hBFC0_0000},
    '{6'd32, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'hBFC0_0480},
    '{6'd37, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'hBFC0_0480}
  };

  function automatic exp_t model(int code, bit slot, bit rf, bit [1:0] cu, bit [1:0] rg,
                                 bit wide, bit dm, bit [31:0] st, bit [31:0] ca,
                                 bit [31:0] db, bit [31:0] eb, bit [31:0] pc);
    exp_t r;
    int c;
    bit exl, bev;
    bit [31:0] off;
    c = (code == 0 && dm) ? 33 : code;
    exl = st[1];
    bev = st[22];
    r = '0;
    r.st = st; r.ca = ca; r.db = db; r.dm = dm;
    r.sav = (slot && c != 32) ? pc - 32'd4 : pc;
    if (c inside {[0:13], 15, 18, [22:25], 30}) begin
      r.v = 1'b1;
      off = 32'h180;
      if (c == 0 && ca[23]) off = 32'h200;
      if ((c == 2 || c == 3) && rf && !exl) begin
        off = 32'h0;
        if (wide && ((rg == 0 && st[5]) || (rg == 1 && st[6]) || (rg == 3 && st[7])))
          off = 32'h80;
      end
      if (c == 30) off = bev ? 32'h100 : 32'h2000_0100;
      r.pc = (bev ? 32'hBFC0_0200 : {eb[31:10], 10'h0}) + off;
      if (!exl) begin
        r.ew = 1'b1; r.ca[31] = slot; r.st[1] = 1'b1; r.st[4:3] = 2'b00;
      end
      r.ca[6:2] = c[4:0];
      if (c == 11) r.ca[29:28] = cu;
    end else if (c == 38 || c == 39) begin
      r.v = 1'b1; r.rw = 1'b1; r.pc = 32'hBFC0_0000;
      if (c == 38) r.st[20] = 1'b1; else r.st[19] = 1'b1;
      r.st[2] = 1'b1; r.st[22] = 1'b1; r.st[4:3] = 2'b00;
      if (!exl) r.ca[31] = 1'b0;
    end else if (c >= 32 && c <= 37) begin
      r.v = 1'b1; r.dw = 1'b1; r.dm = 1'b1; r.pc = 32'hBFC0_0480; r.st[4:3] = 2'b00;
      if (!exl) r.ca[31] = 1'b0;
      case (c)
        32: r.db[0] = 1'b1;
        33: r.db[5] = 1'b1;
        34: r.db[4] = 1'b1;
        35: r.db[1] = 1'b1;
        36: r.db[3] = 1'b1;
        default: r.db[2] = 1'b1;
      endcase
    end else begin
      r.e = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one request, compare every output against the model
  task automatic apply(int code, bit slot, bit rf, bit [1:0] cu, bit [1:0] rg,
                       bit wide, bit dm, bit [31:0] st, bit [31:0] ca, bit [31:0] pc);
    exp_t r;
    @(negedge clk);
    req_valid = 1'b1; req_code = code[5:0]; in_slot = slot; tlb_refill = rf;
    cu_num = cu; bad_region = rg; wide_mode = wide; dbg_mode_i = dm;
    status_i = st; cause_i = ca; req_pc = pc;
    r = model(code, slot, rf, cu, rg, wide, dm, st, ca, DBGV, EBASE, pc);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 wb_valid", {31'b0, wb_valid}, {31'b0, r.v});
    chk("R12 wb_err", {31'b0, wb_err}, {31'b0, r.e});
    chk("R6 epc_we", {31'b0, epc_we}, {31'b0, r.ew});
    chk("R8 errepc_we", {31'b0, errepc_we}, {31'b0, r.rw});
    chk("R9 depc_we", {31'b0, depc_we}, {31'b0, r.dw});
    chk("R6/R8 status", status_o, r.st);
    chk("R7/R11 cause", cause_o, r.ca);
    chk("R9 debug", debug_o, r.db);
    chk("R10 dbg_mode", {31'b0, dbg_mode_o}, {31'b0, r.dm});
    chk("R11 slot_clr", {31'b0, slot_clr}, {31'b0, r.v});
    if (r.v) chk("R2 new pc", pc_o, r.pc);
    if (r.ew) chk("R6 epc", epc_o, r.sav);
    if (r.rw) chk("R8 errepc", errepc_o, r.sav);
    if (r.dw) chk("R9 depc", depc_o, r.sav);
  endtask

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 wb_valid", {31'b0, wb_valid}, 32'd0);
    chk("R1 pc_o", pc_o, 32'd0);
    chk("R1 status_o", status_o, 32'd0);
    chk("R1 epc_we", {31'b0, epc_we}, 32'd0);
    rst_n = 1'b1;

    // table of worked vectors (R2 R3 R4 R5 R8 R9)
    for (int i = 0; i < NTV; i++) begin
      apply(int'(TV[i].code), TV[i].slot, TV[i].refill, 2'd0, 2'd0, 1'b0, 1'b0,
            TV[i].st, TV[i].ca, 32'h0040_2000);
      chk("R2 table pc", pc_o, TV[i].exp_pc);
    end

    // full sweep of codes, slot, EXL and BEV
    for (int c = 0; c < 64; c++)
      for (int m = 0; m < 8; m++)
        apply(c, m[0], 1'b1, c[1:0], 2'd0, 1'b0, 1'b0,
              {9'b0, m[2], 19'b0, 1'b1, m[1], 1'b0} | 32'h0000_0018,
              32'h8000_0300, 32'h0040_1000 + 32'(c * 4));

    // R4: wide refill by region
    apply(2, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 32'h0040_0020, 32'h0, 32'h1000);
    chk("R4 region0 UX", pc_o, 32'hBFC0_0280);
    apply(3, 1'b0, 1'b1, 2'd0, 2'd1, 1'b1, 1'b0, 32'h0040_0040, 32'h0, 32'h1000);
    chk("R4 region1 SX", pc_o, 32'hBFC0_0280);
    apply(3, 1'b0, 1'b1, 2'd0, 2'd3, 1'b1, 1'b0, 32'h0040_0080, 32'h0, 32'h1000);
    chk("R4 region3 KX", pc_o, 32'hBFC0_0280);
    apply(2, 1'b0, 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 32'h0040_00E0, 32'h0, 32'h1000);
    chk("R4 region2", pc_o, 32'hBFC0_0200);
    apply(2, 1'b0, 1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 32'h0040_0080, 32'h0, 32'h1000);
    chk("R4 narrow", pc_o, 32'hBFC0_0200);
    apply(2, 1'b0, 1'b1, 2'd0, 2'd1, 1'b1, 1'b0, 32'h0040_0020, 32'h0, 32'h1000);
    chk("R4 region1 no SX", pc_o, 32'hBFC0_0200);

    // R7: coprocessor number
    apply(11, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h2000);
    chk("R7 cop number", {30'b0, cause_o[29:28]}, 32'd2);
    chk("R7 exc code", {27'b0, cause_o[6:2]}, 32'd11);

    // R10: interrupt inside debug mode
    apply(0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h0, 32'h3000);
    chk("R10 redirect pc", pc_o, 32'hBFC0_0480);
    chk("R10 dint bit", {31'b0, debug_o[5]}, 32'd1);
    chk("R10 depc", depc_o, 32'h0000_2FFC);

    // R6: delay slot with EXL clear
    apply(9, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h5000);
    chk("R6 slot epc", epc_o, 32'h0000_4FFC);
    chk("R6 BD set", {31'b0, cause_o[31]}, 32'd1);

    // R11: BD kept under EXL, cleared without
    apply(39, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 32'h2, 32'h8000_0000, 32'h6000);
    chk("R11 BD kept", {31'b0, cause_o[31]}, 32'd1);
    apply(34, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h8000_0000, 32'h6000);
    chk("R11 BD cleared", {31'b0, cause_o[31]}, 32'd0);

    // R12: illegal code passes registers through
    apply(14, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 32'h1234_5678, 32'h8765_4321, 32'h7000);
    chk("R12 err", {31'b0, wb_err}, 32'd1);
    chk("R12 status held", status_o, 32'h1234_5678);
    chk("R12 cause held", cause_o, 32'h8765_4321);

    // R13: single-cycle result
    @(negedge clk);
    chk("R13 pulse ends", {30'b0, wb_valid, wb_err}, 32'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule